// File: doc/BRIEF.md
# Pipeline Interlock and Squash Controller

This block decides, every cycle, whether a five-stage in-order pipeline advances normally, holds its front end for one cycle, discards a wrongly fetched instruction, or abandons the instructions younger than an arithmetic fault and redirects fetch to a fixed trap entry. It is purely combinational from its inputs to its outputs. The clock and reset feed only the built-in property checks.

Three events are recognised. A load in the execute stage whose destination register matches either source register of the instruction in decode causes a one-cycle hold. The front end is frozen and the control fields entering the execute stage are forced to zero, which inserts a bubble. A branch found taken in decode squashes the single instruction fetched behind it, because fetch always assumes not-taken. A signed overflow in the execute stage squashes the three stage registers in front of memory. It also steers the program counter to the trap entry and raises the enables that capture the faulting PC and the fault reason.

When events coincide, the fault wins over the branch, and the branch wins over the hold. The trap entry address and the overflow reason code are parameters, and both are presented on output ports.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: A hold is requested when the execute-stage load flag is 1 and the execute-stage destination field equals the decode-stage first source field or second source field. This includes a destination of register 0.
- R2: During a hold, `pc_we` and `ifid_we` are 0 and `idex_bubble` is 1. In every other case `pc_we` and `ifid_we` are 1 and `idex_bubble` is 0.
- R3: A hold lasts only while its condition is present. Once the bubble occupies the execute stage (load flag 0), the same decode instruction proceeds with no hold.
- R4: A taken branch with no overflow raises `if_flush` only. `idex_flush` and `exmem_flush` stay 0, and no hold is raised even if a load hazard is present.
- R5: An overflow raises `if_flush`, `idex_flush`, `exmem_flush` and `pc_trap_sel` together, whatever the other inputs are.
- R6: An overflow raises `epc_we` and `cause_we` in the same cycle. Neither is ever 1 without an overflow.
- R7: With no overflow, no taken branch and no load hazard, every flush, select and enable output other than `pc_we` and `ifid_we` is 0.
- R8: `trap_addr` always equals parameter TRAP_ADDR (default 32'h8000_0180), and `cause_code` always equals parameter OVF_CAUSE (default 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for property checks |
| rst_n | input | 1 | Active-low reset for property checks |
| id_src_a | input | REGW | Decode-stage first source register |
| id_src_b | input | REGW | Decode-stage second source register |
| ex_is_load | input | 1 | Execute-stage instruction reads memory |
| ex_dst | input | REGW | Execute-stage load destination register |
| id_br_taken | input | 1 | Branch resolved taken in decode |
| ex_overflow | input | 1 | Signed overflow in execute |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register update enable |
| idex_bubble | output | 1 | Select zeros into execute control fields |
| if_flush | output | 1 | Squash the fetch/decode register |
| idex_flush | output | 1 | Squash the decode/execute register |
| exmem_flush | output | 1 | Squash the execute/memory register |
| pc_trap_sel | output | 1 | Select trap entry into the PC mux |
| epc_we | output | 1 | Capture faulting PC |
| cause_we | output | 1 | Capture fault reason |
| cause_code | output | CAUSEW | Reason code for overflow |
| trap_addr | output | ADDRW | Trap entry address |

## Verification
The bench builds the block with a non-default trap entry of 32'h0000_0400 and a reason code of 12. A value that a constant left in place of the parameter could produce would therefore show up on the ports. Register width stays at 5. The random phase draws register numbers from a narrow range, so source/destination matches, register-0 matches and coincident branch, overflow and hazard events all come up often enough to exercise the priority order.

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int REGW = 5,
  parameter int ADDRW = 32,
  parameter int CAUSEW = 5,
  parameter logic [ADDRW-1:0] TRAP_ADDR = 32'h8000_0180,
  parameter logic [CAUSEW-1:0] OVF_CAUSE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REGW-1:0]   id_src_a,
  input  logic [REGW-1:0]   id_src_b,
  input  logic              ex_is_load,
  input  logic [REGW-1:0]   ex_dst,
  input  logic              id_br_taken,
  input  logic              ex_overflow,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_bubble,
  output logic              if_flush,
  output logic              idex_flush,
  output logic              exmem_flush,
  output logic              pc_trap_sel,
  output logic              epc_we,
  output logic              cause_we,
  output logic [CAUSEW-1:0] cause_code,
  output logic [ADDRW-1:0]  trap_addr
);

  logic load_use;
  logic squash_br;
  logic hold;

  assign load_use  = ex_is_load && ((ex_dst == id_src_a) || (ex_dst == id_src_b));
  assign squash_br = id_br_taken && !ex_overflow;
  assign hold      = load_use && !id_br_taken && !ex_overflow;

  assign pc_we       = !hold;
  assign ifid_we     = !hold;
  assign idex_bubble = hold;

  assign if_flush    = ex_overflow || squash_br;
  assign idex_flush  = ex_overflow;
  assign exmem_flush = ex_overflow;
  assign pc_trap_sel = ex_overflow;
  assign epc_we      = ex_overflow;
  assign cause_we    = ex_overflow;

  assign cause_code = OVF_CAUSE;
  assign trap_addr  = TRAP_ADDR;

  // R5: overflow squashes three stages and redirects fetch
  p_ovf_squash_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ex_overflow |-> (if_flush && idex_flush && exmem_flush && pc_trap_sel));

  // R6: fault capture enables move together with the trap select
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (epc_we || cause_we) |-> (pc_trap_sel && epc_we && cause_we));

  // R2: a bubble always comes with a frozen front end
  p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_we && !ifid_we && !if_flush));

  // R4: a taken branch without fault touches only the fetch register
  p_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_br_taken && !ex_overflow) |-> (if_flush && !idex_flush && !exmem_flush && pc_we));

  // R1: a matching load with nothing higher priority must hold
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && (ex_dst == id_src_a) && !id_br_taken && !ex_overflow) |-> idex_bubble);

endmodule

// File: tb/pipe_hazard_ctrl_tb.sv
module pipe_hazard_ctrl_tb;
  localparam int REGW = 5;
  localparam int ADDRW = 32;
  localparam int CAUSEW = 5;
  localparam logic [ADDRW-1:0] T_ADDR = 32'h0000_0400;
  localparam logic [CAUSEW-1:0] T_CAUSE = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic [REGW-1:0] src_a = 0, src_b = 0, dst = 0;
  logic is_load = 0, br = 0, ovf = 0;
  logic pc_we, ifid_we, bubble, f_if, f_idex, f_exmem, trap_sel, epc_we, cause_we;
  logic [CAUSEW-1:0] cause;
  logic [ADDRW-1:0] taddr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pipe_hazard_ctrl #(.REGW(REGW), .ADDRW(ADDRW), .CAUSEW(CAUSEW),
                     .TRAP_ADDR(T_ADDR), .OVF_CAUSE(T_CAUSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .id_src_a(src_a), .id_src_b(src_b),
    .ex_is_load(is_load), .ex_dst(dst), .id_br_taken(br), .ex_overflow(ovf),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(bubble), .if_flush(f_if),
    .idex_flush(f_idex), .exmem_flush(f_exmem), .pc_trap_sel(trap_sel),
    .epc_we(epc_we), .cause_we(cause_we), .cause_code(cause), .trap_addr(taddr));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: decide the event class, then the expected outputs
  task automatic compare(input string req);
    int kind; // 0 run, 1 hold, 2 branch squash, 3 fault
    logic [8:0] exp, act;
    if (ovf) kind = 3;
    else if (br) kind = 2;
    else if (is_load && (dst == src_a || dst == src_b)) kind = 1;
    else kind = 0;
    case (kind)
      0: exp = 9'b11_0_000_000;
      1: exp = 9'b00_1_000_000;
      2: exp = 9'b11_0_100_000;
      default: exp = 9'b11_0_111_111;
    endcase
    act = {pc_we, ifid_we, bubble, f_if, f_idex, f_exmem, trap_sel, epc_we, cause_we};
    chk(req, "controls", {23'd0, act}, {23'd0, exp});
    chk("R8", "trap_addr", taddr, T_ADDR);
    chk("R8", "cause_code", {27'd0, cause}, {27'd0, T_CAUSE});
  endtask

  task automatic step(input logic [REGW-1:0] a, input logic [REGW-1:0] b, input logic ld,
                      input logic [REGW-1:0] d, input logic bt, input logic ov, input string req);
    @(negedge clk);
    src_a = a; src_b = b; is_load = ld; dst = d; br = bt; ovf = ov;
    #1 compare(req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 compare("R7");                    // reset state: all quiet
    rst_n = 1;
    step(3, 4, 0, 3, 0, 0, "R7");        // match but not a load
    step(3, 4, 1, 3, 0, 0, "R1");        // load hits first source
    step(3, 4, 1, 4, 0, 0, "R1");        // load hits second source
    step(0, 9, 1, 0, 0, 0, "R1");        // register 0 still holds
    step(3, 4, 1, 7, 0, 0, "R7");        // load, no match
    step(5, 6, 1, 6, 0, 0, "R2");        // hold cycle
    step(5, 6, 0, 0, 0, 0, "R3");        // bubble now in EX: proceed
    step(5, 6, 0, 6, 0, 0, "R3");        // later dependent: no hold
    step(1, 2, 0, 0, 1, 0, "R4");        // taken branch
    step(1, 2, 1, 2, 1, 0, "R4");        // branch beats hold
    step(1, 2, 0, 0, 0, 1, "R5");        // overflow alone
    step(1, 2, 1, 1, 1, 1, "R5");        // overflow beats everything
    step(8, 8, 0, 0, 0, 1, "R6");
    step(8, 8, 0, 0, 0, 0, "R6");        // capture enables drop
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
           $urandom_range(0, 3), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0), "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule